// File: doc/BRIEF.md
# RS-485 Driver Enable Pin Controller

This block sits beside a UART and decides what two shared output pins carry. One is the request-to-send pin. The other is a dedicated transceiver-enable pin. Each pin can drive a half-duplex RS-485 driver enable, a hardware flow-control output, or a plain general-purpose value. An 8-bit mode register, written through a simple strobe, selects the function of each pin, the pin that carries the enable, and the polarity of the enable.

The enable follows the transmitter. It asserts when the transmitter leaves idle and stays asserted through the last stop bit. It releases only when a frame completes with the transmit buffer empty. In multidrop operation the enable can also be gated by an address-match flag from the receive side. That flag is latched until the enable releases. Register changes made while an enable is active are held back until that transmission finishes, so a write cannot cut a frame short.

Top module: `rs485_den_ctrl`

## Requirements
- R1: Synchronous reset sets the mode register to 0x01 and drives both pins high. With the flow-control enable low, both pins stay high afterwards until the stimulus changes.
- R2: When mode bits 2:0 are 001, the request-to-send pin is active low and drives the inverse of `rts_req` while `hw_fc_en` is 1. While `hw_fc_en` is 0, the pin is held high (inactive).
- R3: Pins fall back to their GPIO input in these cases. For the request-to-send pin, this applies to codes 000 and 010, to reserved codes 101–111, and to codes 011/100 while bit 4 is 1. For the dedicated pin, it applies to select codes 00 and 11 in bits 6:5.
- R4: In an enable mode, the internal enable sets on the first clock edge where `tx_busy` is 1. It clears on the edge where `tx_frame_done` and `tx_buf_empty` are both 1.
- R5: A `tx_frame_done` pulse while `tx_buf_empty` is 0 leaves the enable asserted.
- R6: Address-match gating works as follows. With code 100 on the request-to-send pin, or select 10 on the dedicated pin, `addr_match` is latched. The pin shows the enable only while the enable is active and the latch is set. The latch clears when the enable releases.
- R7: Bit 4 chooses the enable pin. With bit 4 = 1, select 01/10 in bits 6:5 puts the enable on the dedicated pin. With bit 4 = 0, the dedicated pin shows its GPIO value for those selects.
- R8: Bit 3 sets the polarity of the enable. With bit 3 = 1, the pin is high when the enable is asserted. With bit 3 = 0, the pin is low when the enable is asserted. An idle enable shows the opposite level.
- R9: Bit 7 of the mode register has no effect on either pin.
- R10: A mode write while the enable is active does not change pin behaviour until the enable releases. A mode write while the enable is idle takes effect on the pins two edges after the write strobe is sampled.
- R11: All pin outputs are registered. GPIO and flow-control inputs reach the pins one edge after they are sampled. Transmitter status and address match reach the pins two edges after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| tx_busy | input | 1 | Transmitter not idle |
| tx_frame_done | input | 1 | Pulse at end of last stop bit |
| tx_buf_empty | input | 1 | No further data queued for transmit |
| addr_match | input | 1 | Multidrop address-match pulse |
| rts_req | input | 1 | Flow-control request-to-send level (1 = assert) |
| hw_fc_en | input | 1 | Hardware flow-control enable |
| gpio_rts | input | 1 | GPIO value for the request-to-send pin |
| gpio_ded | input | 1 | GPIO value for the dedicated pin |
| pin_rts | output | 1 | Request-to-send / enable / GPIO pin |
| pin_ded | output | 1 | Dedicated enable / GPIO pin |

## Verification
Latency is fixed for each result. The GPIO and flow-control inputs reach the pins one clock edge after they are sampled. Transmitter status, address match and mode writes take two edges, because they first pass through the enable or mode register and then through the pin register. The bench drives on the falling edge and samples on a later falling edge, after exactly the number of rising edges due. For the transmit-status path it also samples after one edge, to confirm that the pin has not moved early. The static sweep covers every one of the 256 mode values against all sixteen GPIO and flow-control input combinations.

// File: rtl/rs485_den_pkg.sv
package rs485_den_pkg;
  typedef enum logic [1:0] {
    PF_GPIO     = 2'd0,
    PF_FLOW     = 2'd1,
    PF_EN       = 2'd2,
    PF_EN_MATCH = 2'd3
  } pin_func_e;

  localparam int MODE_W      = 8;
  localparam int CFG_W       = 7;
  localparam int RTS_CODE_LO = 0;
  localparam int POL_BIT     = 3;
  localparam int ROUTE_BIT   = 4;
  localparam int DED_SEL_LO  = 5;
endpackage

// File: rtl/rs485_den_cfg.sv
module rs485_den_cfg
  import rs485_den_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              freeze,
  output logic [MODE_W-1:0] mode_q,
  output pin_func_e         func_rts,
  output pin_func_e         func_ded,
  output logic              pol
);
  logic [CFG_W-1:0] held_q;
  logic [CFG_W-1:0] eff;
  logic [2:0]       rts_code;
  logic [1:0]       ded_sel;
  logic             route_ded;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RESET_MODE;
    end else if (wr) begin
      mode_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= RESET_MODE[CFG_W-1:0];
    end else if (!freeze) begin
      held_q <= mode_q[CFG_W-1:0];
    end
  end

  assign eff       = freeze ? held_q : mode_q[CFG_W-1:0];
  assign rts_code  = eff[RTS_CODE_LO +: 3];
  assign ded_sel   = eff[DED_SEL_LO +: 2];
  assign route_ded = eff[ROUTE_BIT];
  assign pol       = eff[POL_BIT];

  always_comb begin
    func_rts = PF_GPIO;
    unique case (rts_code)
      3'b001:  func_rts = PF_FLOW;
      3'b011:  func_rts = route_ded ? PF_GPIO : PF_EN;
      3'b100:  func_rts = route_ded ? PF_GPIO : PF_EN_MATCH;
      default: func_rts = PF_GPIO;
    endcase
  end

  always_comb begin
    func_ded = PF_GPIO;
    if (route_ded) begin
      unique case (ded_sel)
        2'b01:   func_ded = PF_EN;
        2'b10:   func_ded = PF_EN_MATCH;
        default: func_ded = PF_GPIO;
      endcase
    end
  end
endmodule

// File: rtl/rs485_den_txgate.sv
module rs485_den_txgate (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic tx_frame_done,
  input  logic tx_buf_empty,
  input  logic addr_match,
  output logic en_active,
  output logic match_lat
);
  logic release_now;

  assign release_now = en_active && tx_frame_done && tx_buf_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_active <= 1'b0;
    end else if (release_now) begin
      en_active <= 1'b0;
    end else if (tx_busy) begin
      en_active <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_lat <= 1'b0;
    end else if (release_now) begin
      match_lat <= 1'b0;
    end else if (addr_match) begin
      match_lat <= 1'b1;
    end
  end
endmodule

// File: rtl/rs485_den_pin.sv
module rs485_den_pin
  import rs485_den_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  pin_func_e func,
  input  logic      pol,
  input  logic      en_plain,
  input  logic      en_gated,
  input  logic      flow_level,
  input  logic      gpio_level,
  output logic      pin_q
);
  logic en_sel;
  logic pin_d;

  always_comb begin
    en_sel = (func == PF_EN_MATCH) ? en_gated : en_plain;
    unique case (func)
      PF_FLOW:             pin_d = flow_level;
      PF_EN, PF_EN_MATCH:  pin_d = pol ? en_sel : ~en_sel;
      default:             pin_d = gpio_level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= RST_LEVEL;
    end else begin
      pin_q <= pin_d;
    end
  end
endmodule

// File: rtl/rs485_den_ctrl.sv
module rs485_den_ctrl
  import rs485_den_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 8'h01,
  parameter logic              PIN_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              tx_busy,
  input  logic              tx_frame_done,
  input  logic              tx_buf_empty,
  input  logic              addr_match,
  input  logic              rts_req,
  input  logic              hw_fc_en,
  input  logic              gpio_rts,
  input  logic              gpio_ded,
  output logic              pin_rts,
  output logic              pin_ded
);
  localparam int NUM_PINS = 2;

  logic [MODE_W-1:0] mode_q;
  logic              en_active;
  logic              match_lat;
  logic              pol;
  pin_func_e         func_rts;
  pin_func_e         func_ded;

  pin_func_e         func_arr [NUM_PINS];
  logic [NUM_PINS-1:0] flow_arr;
  logic [NUM_PINS-1:0] gpio_arr;
  logic [NUM_PINS-1:0] pin_arr;

  rs485_den_cfg #(
    .RESET_MODE(RESET_MODE)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (mode_wr),
    .wdata    (mode_wdata),
    .freeze   (en_active),
    .mode_q   (mode_q),
    .func_rts (func_rts),
    .func_ded (func_ded),
    .pol      (pol)
  );

  rs485_den_txgate u_gate (
    .clk           (clk),
    .rst           (rst),
    .tx_busy       (tx_busy),
    .tx_frame_done (tx_frame_done),
    .tx_buf_empty  (tx_buf_empty),
    .addr_match    (addr_match),
    .en_active     (en_active),
    .match_lat     (match_lat)
  );

  assign func_arr[0] = func_rts;
  assign func_arr[1] = func_ded;
  assign flow_arr    = {1'b1, ~(hw_fc_en & rts_req)};
  assign gpio_arr    = {gpio_ded, gpio_rts};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    rs485_den_pin #(
      .RST_LEVEL(PIN_RST)
    ) u_pin (
      .clk        (clk),
      .rst        (rst),
      .func       (func_arr[i]),
      .pol        (pol),
      .en_plain   (en_active),
      .en_gated   (en_active & match_lat),
      .flow_level (flow_arr[i]),
      .gpio_level (gpio_arr[i]),
      .pin_q      (pin_arr[i])
    );
  end

  assign pin_rts = pin_arr[0];
  assign pin_ded = pin_arr[1];
endmodule

// File: rtl/rs485_den_ctrl_chk.sv
module rs485_den_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_busy,
  input logic       tx_frame_done,
  input logic       tx_buf_empty,
  input logic       addr_match,
  input logic       hw_fc_en,
  input logic       gpio_rts,
  input logic       gpio_ded,
  input logic       pin_rts,
  input logic       pin_ded,
  input logic [7:0] mode_q,
  input logic       en_active,
  input logic       match_lat
);
  // R4: leaving idle sets the enable
  assert_start_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_active && tx_busy) |=> en_active);

  // R4: frame done with empty buffer releases
  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (en_active && tx_frame_done && tx_buf_empty) |=> !en_active);

  // R5: frame done with data pending keeps the enable
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en_active && !(tx_frame_done && tx_buf_empty)) |=> en_active);

  // R6: release clears the match latch
  assert_match_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (en_active && tx_frame_done && tx_buf_empty) |=> !match_lat);

  // R6: a match pulse is latched
  assert_match_set_R6: assert property (@(posedge clk) disable iff (rst)
    (addr_match && !(en_active && tx_frame_done && tx_buf_empty)) |=> match_lat);

  // R3 and R9: all-GPIO setting with any bit 7 passes GPIO values through
  assert_gpio_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q[6:0] == 7'd0 && !en_active)
      |=> (pin_rts == $past(gpio_rts)) && (pin_ded == $past(gpio_ded)));

  // R2: flow control disabled keeps the pin inactive
  assert_fc_off_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:0] == 3'b001 && !hw_fc_en && !en_active) |=> pin_rts);
endmodule

bind rs485_den_ctrl rs485_den_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_busy       (tx_busy),
  .tx_frame_done (tx_frame_done),
  .tx_buf_empty  (tx_buf_empty),
  .addr_match    (addr_match),
  .hw_fc_en      (hw_fc_en),
  .gpio_rts      (gpio_rts),
  .gpio_ded      (gpio_ded),
  .pin_rts       (pin_rts),
  .pin_ded       (pin_ded),
  .mode_q        (mode_q),
  .en_active     (en_active),
  .match_lat     (match_lat)
);

// File: tb/rs485_den_ctrl_tb.sv
module rs485_den_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       tx_busy = 1'b0;
  logic       tx_frame_done = 1'b0;
  logic       tx_buf_empty = 1'b0;
  logic       addr_match = 1'b0;
  logic       rts_req = 1'b0;
  logic       hw_fc_en = 1'b0;
  logic       gpio_rts = 1'b1;
  logic       gpio_ded = 1'b1;
  logic       pin_rts;
  logic       pin_ded;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rs485_den_ctrl u_dut (
    .clk           (clk),
    .rst           (rst),
    .mode_wr       (mode_wr),
    .mode_wdata    (mode_wdata),
    .tx_busy       (tx_busy),
    .tx_frame_done (tx_frame_done),
    .tx_buf_empty  (tx_buf_empty),
    .addr_match    (addr_match),
    .rts_req       (rts_req),
    .hw_fc_en      (hw_fc_en),
    .gpio_rts      (gpio_rts),
    .gpio_ded      (gpio_ded),
    .pin_rts       (pin_rts),
    .pin_ded       (pin_ded)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr = 1'b1;
    mode_wdata = v;
    edges(1);
    mode_wr = 1'b0;
  endtask

  task automatic pulse_release(input logic empty);
    tx_frame_done = 1'b1;
    tx_buf_empty = empty;
    edges(1);
    tx_frame_done = 1'b0;
    tx_buf_empty = 1'b0;
  endtask

  function automatic logic exp_rts(input logic [7:0] v, input logic g, input logic rq, input logic fc);
    if (v[2:0] == 3'b001) return ~(fc & rq);
    if (!v[4] && (v[2:0] == 3'b011 || v[2:0] == 3'b100)) return ~v[3];
    return g;
  endfunction

  function automatic logic exp_ded(input logic [7:0] v, input logic g);
    if (v[4] && (v[6:5] == 2'b01 || v[6:5] == 2'b10)) return ~v[3];
    return g;
  endfunction

  function automatic string tag_rts(input logic [7:0] v);
    if (v[7]) return "R9";
    if (v[2:0] == 3'b001) return "R2";
    if (!v[4] && (v[2:0] == 3'b011 || v[2:0] == 3'b100)) return "R8";
    return "R3";
  endfunction

  function automatic string tag_ded(input logic [7:0] v);
    if (v[7]) return "R9";
    if (v[6:5] == 2'b01 || v[6:5] == 2'b10) return v[4] ? "R8" : "R7";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    edges(2);
    check("R1", pin_rts, 1'b1, "rts pin during reset");
    check("R1", pin_ded, 1'b1, "ded pin during reset");
    rst = 1'b0;
    edges(3);
    check("R1", pin_rts, 1'b1, "rts pin after reset, fc off");
    check("R1", pin_ded, 1'b1, "ded pin after reset");
    hw_fc_en = 1'b1;
    rts_req = 1'b1;
    edges(1);
    check("R1", pin_rts, 1'b0, "default mode drives flow control");
    check("R11", pin_ded, 1'b1, "ded pin unchanged");

    // static sweep of all mode values with the enable idle
    for (int v = 0; v < 256; v++) begin
      write_mode(v[7:0]);
      for (int c = 0; c < 16; c++) begin
        gpio_rts = c[0];
        gpio_ded = c[1];
        rts_req  = c[2];
        hw_fc_en = c[3];
        edges(c == 0 ? 2 : 1);
        check(tag_rts(v[7:0]), pin_rts, exp_rts(v[7:0], c[0], c[2], c[3]), $sformatf("rts mode=%02h in=%0d", v, c));
        check(tag_ded(v[7:0]), pin_ded, exp_ded(v[7:0], c[1]), $sformatf("ded mode=%02h in=%0d", v, c));
      end
    end

    // enable on request-to-send pin, active high
    gpio_rts = 1'b0;
    gpio_ded = 1'b0;
    write_mode(8'h0B);
    edges(1);
    check("R8", pin_rts, 1'b0, "idle enable active-high");
    tx_busy = 1'b1;
    edges(1);
    tx_busy = 1'b0;
    check("R11", pin_rts, 1'b0, "enable not visible after one edge");
    edges(1);
    check("R4", pin_rts, 1'b1, "enable asserted after leaving idle");
    pulse_release(1'b0);
    edges(2);
    check("R5", pin_rts, 1'b1, "frame done with data pending");
    // write during active frame is deferred
    gpio_rts = 1'b0;
    write_mode(8'h00);
    edges(3);
    check("R10", pin_rts, 1'b1, "write deferred during active enable");
    pulse_release(1'b1);
    edges(1);
    check("R10", pin_rts, 1'b0, "deferred write applied after release (GPIO=0)");
    gpio_rts = 1'b1;
    edges(1);
    check("R10", pin_rts, 1'b1, "GPIO follows after release");

    // address-match gating, active high
    write_mode(8'h0C);
    edges(1);
    tx_busy = 1'b1;
    edges(1);
    tx_busy = 1'b0;
    edges(2);
    check("R6", pin_rts, 1'b0, "no match keeps enable inactive");
    addr_match = 1'b1;
    edges(1);
    addr_match = 1'b0;
    edges(1);
    check("R6", pin_rts, 1'b1, "latched match asserts enable");
    pulse_release(1'b1);
    edges(1);
    check("R6", pin_rts, 1'b0, "release drops gated enable");
    tx_busy = 1'b1;
    edges(1);
    tx_busy = 1'b0;
    edges(2);
    check("R6", pin_rts, 1'b0, "latch cleared for next frame");
    pulse_release(1'b1);
    edges(2);

    // dedicated pin, active low
    write_mode(8'h30);
    edges(1);
    check("R8", pin_ded, 1'b1, "idle active-low enable high");
    check("R7", pin_rts, 1'b1, "rts pin GPIO when routed away");
    tx_busy = 1'b1;
    edges(1);
    tx_busy = 1'b0;
    edges(1);
    check("R7", pin_ded, 1'b0, "dedicated enable asserted low");
    pulse_release(1'b1);
    edges(1);
    check("R4", pin_ded, 1'b1, "dedicated enable released");

    // dedicated pin with match gating and reserved bit 7 set
    write_mode(8'hD8);
    edges(1);
    tx_busy = 1'b1;
    addr_match = 1'b1;
    edges(1);
    tx_busy = 1'b0;
    addr_match = 1'b0;
    edges(1);
    check("R9", pin_ded, 1'b1, "gated dedicated enable with bit 7 set");
    pulse_release(1'b1);
    edges(1);
    check("R6", pin_ded, 1'b0, "gated dedicated enable released");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule